// File: doc/BRIEF.md
# Errored Packet Insertion Controller

This block decides, one outgoing packet at a time, whether the packet should be marked as errored for line testing. A packet-start strobe marks each packet. When the block is armed, a divider counts packets and flags one in every x·10^y packets. The mantissa x and the exponent y come from a 7-bit rate setting. A finite error budget ends a run and raises a sticky completion flag. A budget of all ones makes the run continuous. The completion flag can also drive an interrupt request.

A second error source runs alongside the first. When manual mode is enabled, every rising edge on a manual insert input is latched and applied to the next packet start. The manual source is independent of whether an automatic run is active. The block only produces the per-packet corrupt decision. Changing packet contents and decoding the register bus belong to neighbouring logic.

Top module: `epi_ctrl`

## Requirements
- R1: After reset, `corrupt`, `done` and `irq` are low and no automatic run is active.
- R2: While armed with mantissa x = `rate_cfg[3:0]` (nonzero) and exponent y = `rate_cfg[6:4]`, exactly one in every x·10^y packet starts is flagged. Counting restarts at arm, and the last packet of each group is the one flagged. Code 01h flags every packet, 0Fh every 15th and 11h every 10th. `corrupt` is a one-cycle pulse in the cycle after the `pkt_start` cycle.
- R3: Exponent codes 6 and 7 both select 10^6. With codes 61h and 71h, no packet among the first several hundred is flagged.
- R4: A mantissa of zero disables rate-based insertion, whatever the exponent is.
- R5: No rate-based flag occurs before `arm` is pulsed. A `stop` pulse returns the block to idle, and no further rate-based flags follow.
- R6: With `err_count` not equal to FFh, the run ends after `err_count` rate-based flags. `done` sets in the cycle after the last flagged packet start, and no later packet is rate-flagged.
- R7: With `err_count` = FFh, the run is continuous and `done` never sets.
- R8: `done` stays set until `done_clr` is pulsed. `irq` is high exactly while `done` and `irq_en` are both high.
- R9: While `man_en` is 0, `man_in` has no effect. While `man_en` is 1, each 0-to-1 transition of `man_in` flags exactly one packet: the next packet start in a later cycle. This works whether or not a run is active, and it does not consume the error budget.
- R10: A pending manual error and a rate-based error on the same packet start produce a single one-cycle `corrupt` pulse.
- R11: A `rate_wr` pulse reloads the packet divider to zero. Counting restarts at the next packet start.
- R12: Pulsing `arm` with `err_count` = 0 sets `done` at once, without arming and without flagging any packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | One-cycle strobe per outgoing packet |
| rate_cfg | input | 7 | Rate setting: [3:0] mantissa, [6:4] exponent |
| rate_wr | input | 1 | Strobe marking a write of the rate setting; reloads the divider |
| err_count | input | 8 | Error budget; FFh means continuous |
| arm | input | 1 | Write-only start strobe |
| stop | input | 1 | Strobe that ends a run and reloads the divider |
| man_en | input | 1 | Enables manual edge insertion |
| man_in | input | 1 | Manual insert input, edge sensitive |
| irq_en | input | 1 | Completion interrupt enable |
| done_clr | input | 1 | Write-one-to-clear for the completion flag |
| corrupt | output | 1 | Pulse: the packet just started is to be errored |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench keeps a reference model that uses one integer packet counter modulo x·10^y. The RTL instead uses a cascade of decade digits. Directed cases cover codes 01h, 0Fh and 11h, whose periods of 1, 15 and 10 separate errors in the mantissa path from errors in the decade path. Codes 61h and 71h show that the exponent saturates, and a zero mantissa shows that the divider is disabled. A manual edge that lands on a rate-based hit shows whether the two sources are merged or counted twice. Finite, zero and continuous budgets show where a run ends. Random rate codes with small periods, random packet gaps, random manual edges and mid-run `rate_wr` pulses then test the divider phase, the reload and the budget together.

// File: rtl/epi_pkg.sv
// Shared widths for the errored packet insertion controller.
// Assumes the rate setting is a 4-bit mantissa and a 3-bit exponent.
package epi_pkg;
    localparam int MANT_W = 4;
    localparam int EXP_W  = 3;
    localparam int RATE_W = MANT_W + EXP_W;
    localparam int CNT_W  = 8;
    localparam int NDEC   = 6;
    localparam int DIG_W  = 4;
    typedef logic [DIG_W-1:0] digit_t;
endpackage

// File: rtl/epi_rate_div.sv
// Packet divider: a cascade of NDEC decade digits followed by a mantissa
// counter. It flags the last packet of every mant*10^min(expo,NDEC) ticks.
// Assumes tick is gated by the caller and clear accompanies any rate change.
module epi_rate_div
    import epi_pkg::*;
#(
    parameter int N_DEC = NDEC,
    parameter int M_W   = MANT_W,
    parameter int E_W   = EXP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           tick,
    input  logic [M_W-1:0] mant,
    input  logic [E_W-1:0] expo,
    output logic           hit
);
    localparam int YW = E_W + 4;

    logic [N_DEC:0] carry;
    logic [YW-1:0]  y_eff;
    logic [M_W-1:0] mcnt;
    logic [M_W-1:0] mlast;

    // saturate the exponent at the number of decade stages
    always_comb begin
        if (int'(expo) > N_DEC) y_eff = YW'(N_DEC);
        else                    y_eff = YW'(expo);
    end

    assign carry[0] = tick;

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        digit_t digit;
        logic   active;
        assign active = (int'(y_eff) > g);

        // ripple carry: pass through inactive stages, wrap active ones at 9
        always_comb begin
            if (active) carry[g+1] = carry[g] && (digit == digit_t'(9));
            else        carry[g+1] = carry[g];
        end

        // advance one decade digit
        always_ff @(posedge clk) begin
            if (!rst_n || clear || !active) digit <= '0;
            else if (carry[g])              digit <= (digit == digit_t'(9)) ? '0 : digit + 1'b1;
        end

        p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            digit <= digit_t'(9));
    end

    assign mlast = mant - 1'b1;
    assign hit   = carry[N_DEC] && (mant != '0) && (mcnt == mlast);

    // mantissa counter steps once per full decade roll-over
    always_ff @(posedge clk) begin
        if (!rst_n || clear)   mcnt <= '0;
        else if (carry[N_DEC]) mcnt <= hit ? '0 : mcnt + 1'b1;
    end

    p_hit_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick);
    p_zero_mant_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mant == '0) |-> !hit);
endmodule

// File: rtl/epi_man_edge.sv
// Manual insertion: detects 0-to-1 edges of man_in while enabled and
// holds one pending request until the next packet start consumes it.
// Assumes man_in is synchronous to clk.
module epi_man_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic man_en,
    input  logic man_in,
    input  logic pkt_start,
    output logic pend
);
    logic prev;
    logic edge_seen;

    assign edge_seen = man_en && man_in && !prev;

    // remember the previous level of the manual input
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= man_in;
    end

    // set on an edge, drop when a packet start consumes the request
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (edge_seen) pend <= 1'b1;
        else if (pkt_start) pend <= 1'b0;
    end

    p_pend_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(man_en));
    p_pend_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(pkt_start));
endmodule

// File: rtl/epi_run_ctl.sv
// Run control: arms on the start strobe, counts rate-based errors against
// the budget, ends the run and keeps a sticky completion flag.
// Assumes arm and stop are never pulsed in the same cycle.
module epi_run_ctl
    import epi_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           stop,
    input  logic           auto_hit,
    input  logic [C_W-1:0] budget,
    input  logic           done_clr,
    output logic           armed,
    output logic           done
);
    localparam logic [C_W-1:0] CONT = '1;

    logic [C_W-1:0] hits;
    logic           last_hit;
    logic           done_set;

    assign last_hit = armed && auto_hit && (budget != CONT) && (hits + 1'b1 == budget);
    assign done_set = (arm && (budget == '0)) || (!arm && !stop && last_hit);

    // run state and error tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            hits  <= '0;
        end else if (arm) begin
            armed <= (budget != '0);
            hits  <= '0;
        end else if (stop || last_hit) begin
            armed <= 1'b0;
        end else if (armed && auto_hit) begin
            hits  <= hits + 1'b1;
        end
    end

    // sticky completion flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (done_set) done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end

    p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(armed || arm));
    p_cont_never_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && budget == CONT && !arm && !done) |=> !done);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(done_clr));
endmodule

// File: rtl/epi_ctrl.sv
// Errored packet insertion controller top. It merges the rate-based and
// manual error sources into one corrupt pulse per packet start.
// Assumes that pkt_start, arm, stop, rate_wr and done_clr are one-cycle strobes.
module epi_ctrl
    import epi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic [RATE_W-1:0] rate_cfg,
    input  logic              rate_wr,
    input  logic [CNT_W-1:0]  err_count,
    input  logic              arm,
    input  logic              stop,
    input  logic              man_en,
    input  logic              man_in,
    input  logic              irq_en,
    input  logic              done_clr,
    output logic              corrupt,
    output logic              done,
    output logic              irq
);
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  expo;
    logic              armed;
    logic              tick;
    logic              auto_hit;
    logic              man_pend;
    logic              reload;

    assign mant   = rate_cfg[MANT_W-1:0];
    assign expo   = rate_cfg[RATE_W-1:MANT_W];
    assign reload = rate_wr || arm || stop;
    assign tick   = pkt_start && armed && !reload && (mant != '0);

    epi_rate_div #(.N_DEC(NDEC), .M_W(MANT_W), .E_W(EXP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(reload), .tick(tick),
        .mant(mant), .expo(expo), .hit(auto_hit)
    );

    epi_man_edge u_man (
        .clk(clk), .rst_n(rst_n), .man_en(man_en), .man_in(man_in),
        .pkt_start(pkt_start), .pend(man_pend)
    );

    epi_run_ctl #(.C_W(CNT_W)) u_run (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .auto_hit(auto_hit),
        .budget(err_count), .done_clr(done_clr), .armed(armed), .done(done)
    );

    // one corrupt pulse per flagged packet start, either source
    always_ff @(posedge clk) begin
        if (!rst_n) corrupt <= 1'b0;
        else        corrupt <= pkt_start && (auto_hit || man_pend);
    end

    assign irq = done && irq_en;

    p_corrupt_on_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        corrupt |-> $past(pkt_start));
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !armed && !man_pend) |=> !corrupt);
    p_manual_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && man_pend) |=> corrupt);
    p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && irq_en));
endmodule

// File: tb/sim_epi_ctrl.sv
module sim_epi_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0, rate_wr = 1'b0, arm = 1'b0, stop = 1'b0;
    logic [6:0] rate_cfg = '0;
    logic [7:0] err_count = '0;
    logic       man_en = 1'b0, man_in = 1'b0, irq_en = 1'b0, done_clr = 1'b0;
    logic       corrupt, done, irq;

    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    // reference model state
    bit          m_arm, m_done, m_pend, m_prev;
    int unsigned m_cnt, m_hits;

    always #(CLK_P/2) clk = ~clk;

    epi_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .rate_cfg(rate_cfg),
        .rate_wr(rate_wr), .err_count(err_count), .arm(arm), .stop(stop),
        .man_en(man_en), .man_in(man_in), .irq_en(irq_en), .done_clr(done_clr),
        .corrupt(corrupt), .done(done), .irq(irq)
    );

    function automatic int unsigned period(input logic [6:0] c);
        int unsigned p = c[3:0];
        int y = (c[6:4] > 3'd6) ? 6 : int'(c[6:4]);
        for (int i = 0; i < y; i++) p = p * 10;
        return p;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", tag, what, act, exp_v, $time);
        end
    endtask

    task automatic model_reset();
        m_arm = 0; m_done = 0; m_pend = 0; m_prev = 0; m_cnt = 0; m_hits = 0;
    endtask

    // one cycle: drive, predict, clock, compare
    task automatic step(input bit pkt, input bit a, input bit s, input bit rw,
                        input bit dc, input string tag);
        bit e_corr, ahit, edge_s, last;
        int unsigned n;
        @(negedge clk);
        pkt_start = pkt; arm = a; stop = s; rate_wr = rw; done_clr = dc;
        n = period(rate_cfg);
        ahit   = pkt && m_arm && !(a || s || rw) && (rate_cfg[3:0] != 0) && (m_cnt == n - 1);
        e_corr = pkt && (ahit || m_pend);
        edge_s = man_en && man_in && !m_prev;
        m_prev = man_in;
        if (edge_s) m_pend = 1; else if (pkt) m_pend = 0;
        if (a || s || rw) m_cnt = 0;
        else if (pkt && m_arm && rate_cfg[3:0] != 0) m_cnt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
        last = ahit && err_count != 8'hFF && (m_hits + 1 == err_count);
        if (a) begin
            if (err_count == 0) m_done = 1; else begin m_arm = 1; m_hits = 0; end
        end else if (s) m_arm = 0;
        else if (last) begin m_arm = 0; m_done = 1; end
        else if (ahit) m_hits++;
        if (!(a && err_count == 0) && !(!a && !s && last) && dc) m_done = 0;
        @(posedge clk); #1;
        chk(tag, "corrupt", corrupt, e_corr);
        chk(tag, "done", done, m_done);
        chk(tag, "irq", irq, m_done && irq_en);
    endtask

    task automatic set_rate(input logic [6:0] c, input string tag);
        rate_cfg = c;
        step(0, 0, 0, 1, 0, tag);
    endtask

    task automatic pkts(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, tag);
    endtask

    task automatic count_flags(input int n, input string tag, output int flags);
        flags = 0;
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 0, 0, tag);
            if (corrupt) flags++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int f;
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "corrupt", corrupt, 0);
        chk("R1", "done", done, 0);
        chk("R1", "irq", irq, 0);

        // R5: not armed, no flags
        err_count = 8'hFF;
        set_rate(7'h01, "R5");
        count_flags(5, "R5", f); chk("R5", "flags before arm", f, 0);

        // R2 + R7: every packet, continuous
        step(0, 1, 0, 0, 0, "R7");
        count_flags(20, "R2", f); chk("R2", "flags code 01", f, 20);
        chk("R7", "done continuous", done, 0);
        step(0, 0, 1, 0, 0, "R5");
        count_flags(6, "R5", f); chk("R5", "flags after stop", f, 0);

        // R2: code 0F and 11
        set_rate(7'h0F, "R2"); step(0, 1, 0, 0, 0, "R2");
        count_flags(45, "R2", f); chk("R2", "flags code 0F", f, 3);
        step(0, 0, 1, 0, 0, "R2");
        set_rate(7'h11, "R2"); step(0, 1, 0, 0, 0, "R2");
        count_flags(30, "R2", f); chk("R2", "flags code 11", f, 3);
        step(0, 0, 1, 0, 0, "R2");

        // R3: saturated exponent
        set_rate(7'h61, "R3"); step(0, 1, 0, 0, 0, "R3");
        count_flags(300, "R3", f); chk("R3", "flags code 61", f, 0);
        step(0, 0, 1, 0, 0, "R3");
        set_rate(7'h71, "R3"); step(0, 1, 0, 0, 0, "R3");
        count_flags(300, "R3", f); chk("R3", "flags code 71", f, 0);
        step(0, 0, 1, 0, 0, "R3");

        // R4: zero mantissa
        set_rate(7'h30, "R4"); step(0, 1, 0, 0, 0, "R4");
        count_flags(40, "R4", f); chk("R4", "flags zero mantissa", f, 0);
        step(0, 0, 1, 0, 0, "R4");

        // R6 + R8: finite budget, interrupt, sticky flag
        irq_en = 1'b1; err_count = 8'd3;
        set_rate(7'h02, "R6"); step(0, 1, 0, 0, 0, "R6");
        count_flags(12, "R6", f); chk("R6", "flags budget 3", f, 3);
        chk("R8", "irq level", irq, 1);
        step(0, 0, 0, 0, 0, "R8"); chk("R8", "done sticky", done, 1);
        step(0, 0, 0, 0, 1, "R8"); chk("R8", "done cleared", done, 0);

        // R12: zero budget
        err_count = 8'd0;
        step(0, 1, 0, 0, 0, "R12"); chk("R12", "done at arm", done, 1);
        count_flags(6, "R12", f); chk("R12", "flags zero budget", f, 0);
        step(0, 0, 0, 0, 1, "R12");

        // R9: manual disabled, then enabled while idle
        man_in = 1'b1; step(0, 0, 0, 0, 0, "R9"); man_in = 1'b0;
        count_flags(3, "R9", f); chk("R9", "manual while disabled", f, 0);
        man_en = 1'b1;
        man_in = 1'b1; step(0, 0, 0, 0, 0, "R9");
        man_in = 1'b0;
        count_flags(4, "R9", f); chk("R9", "one manual flag", f, 1);

        // R10: manual edge on a rate hit, budget unaffected
        err_count = 8'hFF; set_rate(7'h03, "R10"); step(0, 1, 0, 0, 0, "R10");
        pkts(2, "R10");
        man_in = 1'b1; step(0, 0, 0, 0, 0, "R10"); man_in = 1'b0;
        step(1, 0, 0, 0, 0, "R10"); chk("R10", "merged flag", corrupt, 1);
        step(0, 0, 0, 0, 0, "R10"); chk("R10", "single pulse", corrupt, 0);

        // R11: reload mid-count
        pkts(2, "R11");
        step(0, 0, 0, 1, 0, "R11");
        count_flags(2, "R11", f); chk("R11", "no flag after reload", f, 0);
        step(1, 0, 0, 0, 0, "R11"); chk("R11", "third after reload", corrupt, 1);
        step(0, 0, 1, 0, 0, "R11");

        // random phase checked by the model
        for (int r = 0; r < 40; r++) begin
            logic [6:0] c;
            c = {($urandom % 2 == 0) ? 3'd0 : 3'd1, 4'($urandom % 16)};
            err_count = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 6);
            irq_en = 1'($urandom);
            set_rate(c, "R2");
            step(0, 1, 0, 0, 0, "R6");
            for (int k = 0; k < 120; k++) begin
                man_in = ($urandom % 9 == 0);
                step(1'($urandom % 3 != 0), 0, 0, ($urandom % 97 == 0),
                     ($urandom % 50 == 0), "R2");
            end
            man_in = 1'b0;
            step(0, 0, 1, 0, 1, "R5");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule